// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block watches the stream of finished conversion results from an analog-to-digital converter and reports when a result falls outside a programmable window set by a low and a high bound. Each result comes with the index of the channel it was taken on and a one-cycle valid strobe. The watchdog can be switched off, can watch every channel, or can watch a single chosen channel.

Results and bounds are both given right-aligned at the active conversion width, which may be 12, 10, 8 or 6 bits. Before the comparison, both are moved onto one 12-bit scale so that a single comparator serves every width. A hit sets a sticky flag. Software clears the flag by writing a one, and the flag reaches the interrupt line only while the interrupt enable is set.

Top module: `awd_window_cmp`

## Requirements
- R1: With `wd_on`=0 the flag is never set, whatever `wd_one` holds. With `wd_on`=1 and `wd_one`=0 results from every channel are checked. With both set to 1, single-channel mode applies.
- R2: In single-channel mode a result is checked only when `smp_chan` equals `wd_chan`. Results from any other channel never set the flag.
- R3: A checked result is out of window when it is strictly greater than the high bound or strictly less than the low bound. A result equal to either bound is inside the window.
- R4: The width code `res_sel` means 00=12, 01=10, 10=8 and 11=6 bits. The result and both bounds are shifted left by 2×`res_sel` within a 12-bit field, and bits shifted past bit 11 are dropped. As a result, bits above the active width have no effect.
- R5: The comparison is made in the cycle in which `smp_vld` is high. The flag is visible after the next rising clock edge.
- R6: The flag stays set, through later in-window results and through idle cycles, until it is cleared.
- R7: `flag_clr`=1 clears the flag at the next edge. If an out-of-window result is checked in the same cycle, the flag stays set.
- R8: `wd_irq` equals the flag while `irq_en`=1 and is 0 while `irq_en`=0. It follows `irq_en` without a clock delay.
- R9: While `rst_n` is low the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Result valid strobe |
| smp_data | input | 12 | Result, right-aligned at the active width |
| smp_chan | input | 5 | Channel index of the result |
| wd_on | input | 1 | Watchdog enable |
| wd_one | input | 1 | Single-channel select |
| wd_chan | input | 5 | Watched channel in single-channel mode |
| thr_hi | input | 12 | High bound, right-aligned |
| thr_lo | input | 12 | Low bound, right-aligned |
| res_sel | input | 2 | Width code |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
A software clear and a new out-of-window result can arrive in the same cycle, and the design must resolve that conflict in favour of the new event. The bench drives both directed and random cycles in which `flag_clr` and `smp_vld` are raised together. It predicts from its window model whether that cycle holds a hit, and checks the flag after the following edge. A lost event shows up as a flag of 0 where the model expects 1. A clear that fails to take effect shows up as a 1 after a clear-only cycle.

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
  parameter int DW = 12,
  parameter int CW = 5,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic [CW-1:0] smp_chan,
  input  logic          wd_on,
  input  logic          wd_one,
  input  logic [CW-1:0] wd_chan,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] thr_lo,
  input  logic [RW-1:0] res_sel,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          wd_flag,
  output logic          wd_irq
);
  localparam int SW = RW + 1;

  logic [SW-1:0] shamt;
  logic [DW-1:0] d_al, hi_al, lo_al;
  logic          chan_ok, outside, hit;

  assign shamt   = {res_sel, 1'b0};
  assign d_al    = smp_data << shamt;
  assign hi_al   = thr_hi << shamt;
  assign lo_al   = thr_lo << shamt;
  assign chan_ok = !wd_one || (smp_chan == wd_chan);
  assign outside = (d_al > hi_al) || (d_al < lo_al);
  assign hit     = smp_vld && wd_on && chan_ok && outside;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wd_flag <= 1'b0;
    else if (hit)      wd_flag <= 1'b1;
    else if (flag_clr) wd_flag <= 1'b0;
  end

  assign wd_irq = wd_flag & irq_en;
endmodule

module awd_window_chk #(
  parameter int DW = 12,
  parameter int CW = 5,
  parameter int RW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [DW-1:0] smp_data,
  input logic [CW-1:0] smp_chan,
  input logic          wd_on,
  input logic          wd_one,
  input logic [CW-1:0] wd_chan,
  input logic [DW-1:0] thr_hi,
  input logic [DW-1:0] thr_lo,
  input logic [RW-1:0] res_sel,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          wd_flag,
  input logic          wd_irq
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_on && !wd_flag) |=> !wd_flag);
  assert_other_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_on && wd_one && smp_chan != wd_chan && !wd_flag) |=> !wd_flag);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !flag_clr) |=> wd_flag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !smp_vld) |=> !wd_flag);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> (wd_flag && irq_en));
  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |-> !wd_flag);
endmodule

bind awd_window_cmp awd_window_chk #(.DW(DW), .CW(CW), .RW(RW)) u_chk (.*);

// File: tb/sim_awd_window_cmp.sv
module sim_awd_window_cmp;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 0, wd_on = 0, wd_one = 0, irq_en = 0, flag_clr = 0;
  logic [11:0] smp_data = 0, thr_hi = 0, thr_lo = 0;
  logic [4:0] smp_chan = 0, wd_chan = 0;
  logic [1:0] res_sel = 0;
  logic wd_flag, wd_irq;
  int n_cmp = 0, n_bad = 0;
  logic exp_flag = 0;
  bit done = 0;

  always #4 clk = ~clk;

  awd_window_cmp u0 (.*);

  function automatic logic f_hit(logic v, logic en, logic one, logic [4:0] wc,
      logic [4:0] ch, logic [11:0] d, logic [11:0] hi, logic [11:0] lo, logic [1:0] rs);
    int sh;
    logic [11:0] da, ha, la;
    sh = 2 * int'(rs);
    da = 12'(d << sh);
    ha = 12'(hi << sh);
    la = 12'(lo << sh);
    if (!v || !en) return 1'b0;
    if (one && ch != wc) return 1'b0;
    return (da > ha) || (da < la);
  endfunction

  task automatic chk(string tag, logic act, logic expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
    end
  endtask

  task automatic step(string tag, logic v, logic en, logic one, logic [4:0] wc,
      logic [4:0] ch, logic [11:0] d, logic [11:0] hi, logic [11:0] lo,
      logic [1:0] rs, logic ie, logic clr);
    logic nxt;
    smp_vld = v; wd_on = en; wd_one = one; wd_chan = wc; smp_chan = ch;
    smp_data = d; thr_hi = hi; thr_lo = lo; res_sel = rs; irq_en = ie; flag_clr = clr;
    nxt = f_hit(v, en, one, wc, ch, d, hi, lo, rs) ? 1'b1 : (clr ? 1'b0 : exp_flag);
    @(negedge clk);
    exp_flag = nxt;
    chk({tag, " flag"}, wd_flag, exp_flag);
    chk({"R8 ", tag, " irq"}, wd_irq, exp_flag & ie);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    @(negedge clk);
    chk("R9 reset flag", wd_flag, 1'b0);
    chk("R9 reset irq", wd_irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 boundaries, all channels, 12-bit
    step("R3 eq high", 1, 1, 0, 0, 3, 12'h800, 12'h800, 12'h100, 0, 1, 0);
    step("R3 eq low",  1, 1, 0, 0, 3, 12'h100, 12'h800, 12'h100, 0, 1, 0);
    step("R3 above",   1, 1, 0, 0, 3, 12'h801, 12'h800, 12'h100, 0, 1, 0);
    step("R6 inside",  1, 1, 0, 0, 3, 12'h400, 12'h800, 12'h100, 0, 1, 0);
    step("R6 idle",    0, 1, 0, 0, 3, 12'h000, 12'h800, 12'h100, 0, 0, 0);
    step("R7 clear",   0, 1, 0, 0, 3, 12'h000, 12'h800, 12'h100, 0, 1, 1);
    step("R3 below",   1, 1, 0, 0, 9, 12'h0FF, 12'h800, 12'h100, 0, 1, 0);
    step("R7 clr+hit", 1, 1, 0, 0, 9, 12'hFFF, 12'h800, 12'h100, 0, 1, 1);
    step("R7 clear2",  0, 1, 0, 0, 9, 12'h000, 12'h800, 12'h100, 0, 1, 1);
    // R1 off mode, single bit set
    step("R1 off",     1, 0, 1, 9, 9, 12'hFFF, 12'h010, 12'h008, 0, 1, 0);
    // R2 single channel
    step("R2 other",   1, 1, 1, 17, 16, 12'hFFF, 12'h010, 12'h008, 0, 1, 0);
    step("R2 match",   1, 1, 1, 17, 17, 12'hFFF, 12'h010, 12'h008, 0, 1, 0);
    step("R8 irq off", 0, 1, 1, 17, 17, 12'h000, 12'h010, 12'h008, 0, 0, 0);
    step("R7 clear3",  0, 1, 1, 17, 17, 12'h000, 12'h010, 12'h008, 0, 1, 1);
    // R4 6-bit: upper garbage bits of the result and bounds are dropped
    step("R4 6b in",   1, 1, 0, 0, 1, 12'hF20, 12'h030, 12'h010, 3, 1, 0);
    step("R4 6b out",  1, 1, 0, 0, 1, 12'h031, 12'hE30, 12'h010, 3, 1, 0);
    step("R7 clear4",  0, 1, 0, 0, 1, 12'h000, 12'h030, 12'h010, 3, 1, 1);
    step("R4 8b eq",   1, 1, 0, 0, 1, 12'h0FF, 12'h3FF, 12'h000, 2, 1, 0);
    step("R5 10b out", 1, 1, 0, 0, 1, 12'h3FF, 12'h3FE, 12'h000, 1, 1, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] rs;
      logic [11:0] mask, hi, lo;
      rs = 2'($urandom_range(0, 3));
      mask = 12'hFFF >> (2 * int'(rs));
      hi = 12'($urandom) & mask;
      lo = 12'($urandom) & mask;
      if (($urandom % 8) == 0) hi = 12'($urandom);
      step("R5 rand", 1'($urandom % 4 != 0), 1'($urandom % 5 != 0), 1'($urandom),
           5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
           12'($urandom) & (($urandom % 6 == 0) ? 12'hFFF : mask),
           hi, lo, rs, 1'($urandom), 1'($urandom % 3 == 0));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule